// File: doc/BRIEF.md
# Downstream Remote Address Translator

The block turns a host access that lands in the imported window into a global shared-memory target. The target is a destination node number and an offset inside that node's virtual local address space. The window address is split into a page index and an in-page offset. The index selects one entry of an internal page table. Each entry holds a valid flag, a node number, a remote page number and a protection tag. Because every entry names its own node and remote page, any imported page can point at any page of the global space.

Two kinds of requester share the lookup port: processor programmed-IO accesses and the local DMA engine. Only DMA requests carry a virtual-interface tag, and that tag must equal the entry's tag. Programmed-IO lookups ignore the entry tag completely. Software fills the table through a separate write port.

The full-size configuration covers a 1 GB window in 16 kB pages. That needs a 16-bit page index and a 14-bit offset. The page index width is a parameter, and its default is kept small.

Top module: `dtr_xlate`

## Requirements
- R1: After reset, `outDone`, `outFault`, `outNode` and `outOffset` are all zero, and every table entry is invalid, so any lookup faults until the entry is written.
- R2: A lookup strobe sampled at a clock edge updates the result registers at that same edge. `outDone` is high for exactly the cycle after each strobe and low otherwise.
- R3: For a lookup that does not fault, `outNode` is the entry's node number. `outOffset` is the entry's remote page number in bits [29:14], concatenated with address bits [13:0] in bits [13:0].
- R4: A lookup that hits an invalid entry sets `outFault`, whatever the value of `lkIsDma`.
- R5: A DMA lookup (`lkIsDma`=1) on a valid entry faults when `lkTag` differs from the entry tag. It succeeds when the two tags are equal.
- R6: A programmed-IO lookup (`lkIsDma`=0) on a valid entry never faults, whatever the value of `lkTag`.
- R7: Whenever `outFault` is set, `outNode` and `outOffset` are zero.
- R8: In a cycle without a lookup strobe, `outNode`, `outOffset` and `outFault` keep their values, even if the table is written meanwhile.
- R9: When a table write and a lookup strobe target the same page index in the same cycle, the lookup returns the entry as it was before the write. A later lookup returns the newly written entry.
- R10: A table write with `tblWrValid`=0 invalidates the entry, so later lookups of that page fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tblWrEn | input | 1 | Table write strobe |
| tblWrIdx | input | 10 | Page index to write |
| tblWrValid | input | 1 | Valid flag written into the entry |
| tblWrNode | input | 16 | Destination node number to store |
| tblWrPage | input | 16 | Remote page number to store |
| tblWrTag | input | 8 | Protection tag to store |
| lkStrobe | input | 1 | Lookup request |
| lkAddr | input | 24 | Window address: page index in bits [23:14], in-page offset in bits [13:0] |
| lkIsDma | input | 1 | 1 for a DMA requester, 0 for programmed IO |
| lkTag | input | 8 | Requesting virtual interface's tag (used only when `lkIsDma` is 1) |
| outDone | output | 1 | Result-update pulse |
| outNode | output | 16 | Translated node number |
| outOffset | output | 30 | Offset in the remote node's space |
| outFault | output | 1 | Translation refused |

## Verification
A software table write and a lookup can hit the same page index in the same clock cycle. The bench provokes this on purpose several times, each time with new contents differing from the old ones. The result must show the pre-write entry. A lookup on the next cycle must show the new one. A randomized stretch mixes writes and lookups on a small set of indices so that such collisions and rewrites also happen by chance. A behavioural table model in the bench judges every cycle, with the write applied after the lookup is evaluated.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  parameter int IDX_W_DEF  = 10;
  parameter int OFF_W_DEF  = 14;
  parameter int NODE_W_DEF = 16;
  parameter int PAGE_W_DEF = 16;
  parameter int TAG_W_DEF  = 8;

  typedef struct packed {
    logic wrTable;
    logic loadResult;
  } dtr_strobe_t;
endpackage

// File: rtl/dtr_ctrl.sv
module dtr_ctrl
  import dtr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tblWrEn,
  input  logic        lkStrobe,
  output dtr_strobe_t strobes,
  output logic        doneQ
);
  always_comb begin
    strobes.wrTable    = tblWrEn;
    strobes.loadResult = lkStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= lkStrobe;
  end
endmodule

// File: rtl/dtr_datapath.sv
module dtr_datapath
  import dtr_pkg::*;
#(
  parameter int IDX_W  = IDX_W_DEF,
  parameter int OFF_W  = OFF_W_DEF,
  parameter int NODE_W = NODE_W_DEF,
  parameter int PAGE_W = PAGE_W_DEF,
  parameter int TAG_W  = TAG_W_DEF,
  localparam int ADDR_W = IDX_W + OFF_W,
  localparam int ROFF_W = PAGE_W + OFF_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  dtr_strobe_t       strobes,
  input  logic [IDX_W-1:0]  tblWrIdx,
  input  logic              tblWrValid,
  input  logic [NODE_W-1:0] tblWrNode,
  input  logic [PAGE_W-1:0] tblWrPage,
  input  logic [TAG_W-1:0]  tblWrTag,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkIsDma,
  input  logic [TAG_W-1:0]  lkTag,
  output logic [NODE_W-1:0] outNode,
  output logic [ROFF_W-1:0] outOffset,
  output logic              outFault
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] validQ;
  logic [NODE_W-1:0]  nodeMem [ENTRIES];
  logic [PAGE_W-1:0]  pageMem [ENTRIES];
  logic [TAG_W-1:0]   tagMem  [ENTRIES];

  logic [IDX_W-1:0] rdIdx;
  logic             rdHit;
  logic             tagOk;
  logic             faultNow;

  always_comb begin
    rdIdx    = lkAddr[ADDR_W-1:OFF_W];
    rdHit    = validQ[rdIdx];
    tagOk    = !lkIsDma || (tagMem[rdIdx] == lkTag);
    faultNow = !rdHit || !tagOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= '0;
    else if (strobes.wrTable) validQ[tblWrIdx] <= tblWrValid;
  end

  always_ff @(posedge clk) begin
    if (strobes.wrTable) begin
      nodeMem[tblWrIdx] <= tblWrNode;
      pageMem[tblWrIdx] <= tblWrPage;
      tagMem[tblWrIdx]  <= tblWrTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outNode   <= '0;
      outOffset <= '0;
      outFault  <= 1'b0;
    end else if (strobes.loadResult) begin
      outFault <= faultNow;
      if (faultNow) begin
        outNode   <= '0;
        outOffset <= '0;
      end else begin
        outNode   <= nodeMem[rdIdx];
        outOffset <= {pageMem[rdIdx], lkAddr[OFF_W-1:0]};
      end
    end
  end

  AST_INVALID_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadResult && !rdHit |=> outFault); // R4

  AST_PIO_NO_TAG_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadResult && !lkIsDma && rdHit |=> !outFault); // R6

  AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    outFault |-> (outNode == '0) && (outOffset == '0)); // R7
endmodule

// File: rtl/dtr_xlate.sv
module dtr_xlate
  import dtr_pkg::*;
#(
  parameter int IDX_W  = IDX_W_DEF,
  parameter int OFF_W  = OFF_W_DEF,
  parameter int NODE_W = NODE_W_DEF,
  parameter int PAGE_W = PAGE_W_DEF,
  parameter int TAG_W  = TAG_W_DEF,
  localparam int ADDR_W = IDX_W + OFF_W,
  localparam int ROFF_W = PAGE_W + OFF_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tblWrEn,
  input  logic [IDX_W-1:0]  tblWrIdx,
  input  logic              tblWrValid,
  input  logic [NODE_W-1:0] tblWrNode,
  input  logic [PAGE_W-1:0] tblWrPage,
  input  logic [TAG_W-1:0]  tblWrTag,
  input  logic              lkStrobe,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkIsDma,
  input  logic [TAG_W-1:0]  lkTag,
  output logic              outDone,
  output logic [NODE_W-1:0] outNode,
  output logic [ROFF_W-1:0] outOffset,
  output logic              outFault
);
  dtr_strobe_t strobes;

  dtr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tblWrEn(tblWrEn), .lkStrobe(lkStrobe),
    .strobes(strobes), .doneQ(outDone)
  );

  dtr_datapath #(
    .IDX_W(IDX_W), .OFF_W(OFF_W), .NODE_W(NODE_W), .PAGE_W(PAGE_W), .TAG_W(TAG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .tblWrIdx(tblWrIdx), .tblWrValid(tblWrValid), .tblWrNode(tblWrNode),
    .tblWrPage(tblWrPage), .tblWrTag(tblWrTag),
    .lkAddr(lkAddr), .lkIsDma(lkIsDma), .lkTag(lkTag),
    .outNode(outNode), .outOffset(outOffset), .outFault(outFault)
  );

  AST_DONE_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    lkStrobe |=> outDone); // R2

  AST_DONE_ONLY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !lkStrobe |=> !outDone); // R2

  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !lkStrobe |=> $stable({outNode, outOffset, outFault})); // R8
endmodule

// File: tb/dtr_xlate_bench.sv
module dtr_xlate_bench;
  localparam int IDX_W = 10, OFF_W = 14, NODE_W = 16, PAGE_W = 16, TAG_W = 8;
  localparam int ADDR_W = IDX_W + OFF_W, ROFF_W = PAGE_W + OFF_W;
  localparam int N = 1 << IDX_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic tblWrEn = 0, tblWrValid = 0, lkStrobe = 0, lkIsDma = 0;
  logic [IDX_W-1:0]  tblWrIdx = '0;
  logic [NODE_W-1:0] tblWrNode = '0;
  logic [PAGE_W-1:0] tblWrPage = '0;
  logic [TAG_W-1:0]  tblWrTag = '0, lkTag = '0;
  logic [ADDR_W-1:0] lkAddr = '0;
  logic              outDone, outFault;
  logic [NODE_W-1:0] outNode;
  logic [ROFF_W-1:0] outOffset;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dtr_xlate u_dtr_xlate (.*);

  // behavioural model
  bit              mValid [N];
  bit              mKilled[N];
  int unsigned     mNode[N], mPage[N], mTag[N];
  bit              eDone, eFault;
  int unsigned     eNode, eOff;
  string           eReq = "R1";

  always @(posedge clk) begin
    if (!rstN) begin
      eDone = 0; eFault = 0; eNode = 0; eOff = 0; eReq = "R1";
      foreach (mValid[i]) begin mValid[i] = 0; mKilled[i] = 0; end
    end else begin
      int idx;
      eDone = lkStrobe;
      if (lkStrobe) begin
        idx = int'(lkAddr >> OFF_W);
        if (!mValid[idx]) begin
          eFault = 1; eNode = 0; eOff = 0; eReq = mKilled[idx] ? "R10" : "R4";
        end else if (lkIsDma && mTag[idx] != lkTag) begin
          eFault = 1; eNode = 0; eOff = 0; eReq = "R5";
        end else begin
          eFault = 0; eNode = mNode[idx];
          eOff = (mPage[idx] << OFF_W) | (lkAddr & ((1 << OFF_W) - 1));
          eReq = lkIsDma ? "R3" : "R6";
        end
        if (tblWrEn && tblWrIdx == idx) eReq = "R9";
      end else eReq = "R8";
      if (tblWrEn) begin
        mValid[tblWrIdx] = tblWrValid; mKilled[tblWrIdx] = !tblWrValid;
        mNode[tblWrIdx] = tblWrNode; mPage[tblWrIdx] = tblWrPage; mTag[tblWrIdx] = tblWrTag;
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN && !done) begin
    chk("R2", outDone, eDone);
    chk(eReq, outFault, eFault);
    chk(eFault ? "R7" : eReq, outNode, eNode);
    chk(eFault ? "R7" : eReq, outOffset, eOff);
  end

  task automatic idle();
    tblWrEn = 0; lkStrobe = 0;
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input bit v, input int node, input int page, input int tag);
    tblWrEn = 1; tblWrIdx = idx[IDX_W-1:0]; tblWrValid = v;
    tblWrNode = node[NODE_W-1:0]; tblWrPage = page[PAGE_W-1:0]; tblWrTag = tag[TAG_W-1:0];
  endtask

  task automatic lk(input int idx, input int off, input bit dma, input int tag);
    lkStrobe = 1; lkAddr = {idx[IDX_W-1:0], off[OFF_W-1:0]}; lkIsDma = dma; lkTag = tag[TAG_W-1:0];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", {outDone, outFault}, 0);
    chk("R1", outNode, 0);
    chk("R1", outOffset, 0);
    lk(5, 7, 0, 0); @(negedge clk); tblWrEn = 0; lkStrobe = 0;
    chk("R1", outFault, 1);
    idle();
    wr(3, 1, 'h1234, 'hABCD, 'h5A); @(negedge clk);
    wr(N - 1, 1, 'hFFFF, 'hFFFF, 'hFF); @(negedge clk);
    wr(0, 1, 1, 0, 0); @(negedge clk);
    idle();
    lk(3, 'h3FFF, 0, 'h11); @(negedge clk); lkStrobe = 0;  // R6
    tblWrEn = 0;
    lk(3, 'h0001, 1, 'h5A); @(negedge clk); lkStrobe = 0;  // R3 R5
    chk("R3", outOffset, {16'hABCD, 14'h0001});
    lk(3, 'h0001, 1, 'h5B); @(negedge clk); lkStrobe = 0;  // R5 R7
    chk("R5", outFault, 1);
    lk(N - 1, 'h3FFF, 1, 'hFF); @(negedge clk); lkStrobe = 0;
    chk("R3", outOffset, 30'h3FFF_FFFF);
    wr(7, 1, 9, 9, 9); @(negedge clk); idle(); idle(); // R8 holds across write
    chk("R8", outOffset, 30'h3FFF_FFFF);
    // R9: same-cycle write and lookup
    wr(3, 1, 'h4321, 'h0F0F, 'h22); lk(3, 5, 0, 0); @(negedge clk); idle();
    chk("R9", outNode, 'h1234);
    lk(3, 5, 0, 0); @(negedge clk); idle();
    chk("R9", outNode, 'h4321);
    // R10: invalidate
    wr(0, 0, 1, 0, 0); @(negedge clk); idle();
    lk(0, 0, 0, 0); @(negedge clk); idle();
    chk("R10", outFault, 1);
    lk(0, 0, 1, 0); @(negedge clk); idle();
    chk("R4", outFault, 1);
    // mixed random traffic on a few indices
    for (int i = 0; i < 3000; i++) begin
      int ia = $urandom_range(0, 7), ib = $urandom_range(0, 7);
      tblWrEn = 0; lkStrobe = 0;
      if ($urandom_range(0, 2) == 0)
        wr(ia, $urandom_range(0, 3) != 0, $urandom, $urandom, $urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0)
        lk(ib, $urandom, $urandom_range(0, 1), $urandom_range(0, 3));
      @(negedge clk);
    end
    idle(); idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule